// File: doc/BRIEF.md
# Source-routed management packet forward-hop rewriter

This block runs once at each node that a source-routed management request crosses on its outbound leg. An upstream parser hands it the header fields of one packet: the direction flag, the hop count, the hop pointer, the two local address fields (source and destination), the final destination address carried for the directed part of the route, and two byte arrays. The forward array lists the exit port to take at each hop. The return array collects the arrival port seen at each hop. The node's own configuration arrives on plain control pins: whether it is a switch or an endpoint, its own local address, and the port the packet came in on.

The block walks the hop pointer forward by one entry. It records the arrival port into the return array, rewrites the two address fields, and returns an action with an egress port. The possible actions are: emit on a port, hand off to a forwarding-table lookup, deliver to the local management agent, pass the header on untouched, or drop it. The all-ones address 16'hFFFF is the permissive address, which any node accepts.

Both data sides use valid/ready. An input beat is taken on a rising edge where `in_valid` and `in_ready` are both high. Its result is presented on the following cycle through a single output register. `in_ready` is high whenever that register is empty or is being emptied in the same cycle. While `out_valid` is high and `out_ready` is low, the output register holds its contents and the block refuses new input.

Top module: `dr_fwd_hop`

## Requirements
- R1: `in_ready` is high whenever `out_valid` is low; an accepted input raises `out_valid` on the next cycle; after reset `out_valid` is low.
- R2: While `out_valid` is high and `out_ready` is low, every output holds its value on the next cycle.
- R3: A packet with direction flag 1, or an endpoint packet whose destination address is not 16'hFFFF, yields action PASS (3), port 0, and hop pointer, addresses and return array unchanged.
- R4: Any other packet whose hop pointer exceeds its hop count, or whose hop count exceeds PATH_LEN-1 (63), yields action DROP (4), port 0, and all fields unchanged.
- R5: When the hop pointer is 0 and below the hop count, the pointer becomes 1 and the return array is left unchanged.
- R6: When the hop pointer is nonzero and below the hop count, a switch writes the arrival port into return entry [pointer] (byte i at bits 8i+7:8i) and an endpoint writes nothing; in both cases the pointer is incremented.
- R7: In the intermediate case, a switch sets both addresses to 16'hFFFF; an endpoint sets the source to its own address and the destination to 16'hFFFF.
- R8: In the intermediate case the action is EMIT (0) and the port is the forward entry at the incremented pointer; forward entry 0 is never used as a port.
- R9: When the hop pointer equals the hop count, the arrival port is written into return entry [pointer] if the pointer is nonzero, and the pointer becomes the hop count plus one.
- R10: In that final case, a switch whose final destination is not 16'hFFFF sets the source to its own address and the destination to the final destination, with action LOOKUP (1) and port 0.
- R11: In that final case, if the final destination is 16'hFFFF both addresses become 16'hFFFF; an endpoint with a final destination other than 16'hFFFF sets the source to its own address and the destination to the final destination; either way the action is LOCAL (2) with port 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| in_valid | input | 1 | Header beat valid |
| in_ready | output | 1 | Block can take a beat |
| in_dir | input | 1 | Direction flag (0 outbound) |
| in_hop_cnt | input | PTR_W | Hop count |
| in_hop_ptr | input | PTR_W | Hop pointer |
| in_slid | input | 16 | Source address |
| in_dlid | input | 16 | Destination address |
| in_dr_dlid | input | 16 | Final destination of directed route |
| in_fwd_path | input | PATH_LEN*PORT_W | Forward exit-port list |
| in_ret_path | input | PATH_LEN*PORT_W | Return arrival-port list |
| cfg_is_switch | input | 1 | 1 for switch, 0 for endpoint |
| cfg_own_lid | input | 16 | Node's own address |
| cfg_in_port | input | PORT_W | Arrival port of this packet |
| out_valid | output | 1 | Result valid |
| out_ready | input | 1 | Consumer takes result |
| out_action | output | 3 | 0 EMIT, 1 LOOKUP, 2 LOCAL, 3 PASS, 4 DROP |
| out_port | output | PORT_W | Egress port for EMIT, else 0 |
| out_hop_ptr | output | PTR_W | Updated hop pointer |
| out_slid | output | 16 | Updated source address |
| out_dlid | output | 16 | Updated destination address |
| out_ret_path | output | PATH_LEN*PORT_W | Updated return list |

## Verification
A wrong hop-pointer update or a wrong case decision shows up on the very next result beat, one cycle after acceptance. It appears as a wrong action code, as an egress port taken from the wrong forward entry, or as an arrival port written into the wrong return byte. A fault in the write enable appears as a stray or missing byte in the return array. The bench therefore compares the whole array on every beat. A fault in the holding logic shows up only while the consumer stalls, so stall phases are run and each held beat is compared with its value from the previous cycle.

// File: rtl/dr_hop_pkg.sv
`timescale 1ns/1ps
package dr_hop_pkg;
  localparam int          LID_W    = 16;
  localparam logic [15:0] PERM_LID = 16'hFFFF;

  typedef enum logic [2:0] {
    ACT_EMIT   = 3'd0,
    ACT_LOOKUP = 3'd1,
    ACT_LOCAL  = 3'd2,
    ACT_PASS   = 3'd3,
    ACT_DROP   = 3'd4
  } hop_act_e;

  typedef enum logic [1:0] {
    K_PASS = 2'd0,
    K_DROP = 2'd1,
    K_MID  = 2'd2,
    K_LAST = 2'd3
  } hop_kind_e;
endpackage

// File: rtl/dr_hop_classify.sv
`timescale 1ns/1ps
module dr_hop_classify
  import dr_hop_pkg::*;
#(
  parameter int PATH_LEN = 64,
  parameter int PTR_W    = 8
) (
  input  logic             dir,
  input  logic [PTR_W-1:0] hop_cnt,
  input  logic [PTR_W-1:0] hop_ptr,
  input  logic [LID_W-1:0] dlid,
  input  logic             is_switch,
  output hop_kind_e        kind
);
  localparam logic [PTR_W-1:0] MAX_CNT = PTR_W'(PATH_LEN - 1);

  // Priority: return-direction and addressed endpoint traffic bypass first
  always_comb begin
    if (dir || (!is_switch && dlid != PERM_LID))
      kind = K_PASS;
    else if (hop_cnt > MAX_CNT || hop_ptr > hop_cnt)
      kind = K_DROP;
    else if (hop_ptr < hop_cnt)
      kind = K_MID;
    else
      kind = K_LAST;
  end
endmodule

// File: rtl/dr_hop_rewrite.sv
`timescale 1ns/1ps
module dr_hop_rewrite
  import dr_hop_pkg::*;
#(
  parameter int PATH_LEN = 64,
  parameter int PTR_W    = 8,
  parameter int PORT_W   = 8
) (
  input  hop_kind_e                    kind,
  input  logic [PTR_W-1:0]             hop_cnt,
  input  logic [PTR_W-1:0]             hop_ptr,
  input  logic [LID_W-1:0]             slid,
  input  logic [LID_W-1:0]             dlid,
  input  logic [LID_W-1:0]             dr_dlid,
  input  logic [PATH_LEN*PORT_W-1:0]   fwd_path,
  input  logic [PATH_LEN*PORT_W-1:0]   ret_path,
  input  logic                         is_switch,
  input  logic [LID_W-1:0]             own_lid,
  input  logic [PORT_W-1:0]            in_port,
  output hop_act_e                     act,
  output logic [PORT_W-1:0]            eg_port,
  output logic [PTR_W-1:0]             ptr_n,
  output logic [LID_W-1:0]             slid_n,
  output logic [LID_W-1:0]             dlid_n,
  output logic [PATH_LEN*PORT_W-1:0]   ret_n
);
  localparam int IDX_W = (PATH_LEN > 1) ? $clog2(PATH_LEN) : 1;

  logic [PTR_W-1:0]  ptr_inc;
  logic [IDX_W-1:0]  nxt_idx;
  logic [IDX_W-1:0]  wr_idx;
  logic              wr_en;
  logic [PORT_W-1:0] fwd_sel;

  assign ptr_inc = hop_ptr + PTR_W'(1);
  assign nxt_idx = ptr_inc[IDX_W-1:0];
  assign wr_idx  = hop_ptr[IDX_W-1:0];
  assign fwd_sel = fwd_path[int'(nxt_idx)*PORT_W +: PORT_W];

  // Arrival port recorded at nonzero pointer: always on the last hop, only switches mid-path
  assign wr_en = (hop_ptr != '0) &&
                 ((kind == K_LAST) || (kind == K_MID && is_switch));

  for (genvar i = 0; i < PATH_LEN; i++) begin : g_ret
    assign ret_n[i*PORT_W +: PORT_W] =
      (wr_en && wr_idx == IDX_W'(i)) ? in_port : ret_path[i*PORT_W +: PORT_W];
  end

  always_comb begin
    act     = ACT_PASS;
    eg_port = '0;
    ptr_n   = hop_ptr;
    slid_n  = slid;
    dlid_n  = dlid;
    unique case (kind)
      K_PASS: act = ACT_PASS;
      K_DROP: act = ACT_DROP;
      K_MID: begin
        act     = ACT_EMIT;
        ptr_n   = ptr_inc;
        eg_port = fwd_sel;
        slid_n  = is_switch ? PERM_LID : own_lid;
        dlid_n  = PERM_LID;
      end
      K_LAST: begin
        ptr_n = hop_cnt + PTR_W'(1);
        if (dr_dlid == PERM_LID) begin
          act    = ACT_LOCAL;
          slid_n = PERM_LID;
          dlid_n = PERM_LID;
        end else begin
          act    = is_switch ? ACT_LOOKUP : ACT_LOCAL;
          slid_n = own_lid;
          dlid_n = dr_dlid;
        end
      end
      default: act = ACT_DROP;
    endcase
  end
endmodule

// File: rtl/dr_hop_oreg.sv
`timescale 1ns/1ps
module dr_hop_oreg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] d,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] q
);
  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      q         <= '0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (in_valid) q <= d;
    end
  end
endmodule

// File: rtl/dr_fwd_hop.sv
`timescale 1ns/1ps
module dr_fwd_hop
  import dr_hop_pkg::*;
#(
  parameter int PATH_LEN = 64,
  parameter int PTR_W    = 8,
  parameter int PORT_W   = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       in_valid,
  output logic                       in_ready,
  input  logic                       in_dir,
  input  logic [PTR_W-1:0]           in_hop_cnt,
  input  logic [PTR_W-1:0]           in_hop_ptr,
  input  logic [15:0]                in_slid,
  input  logic [15:0]                in_dlid,
  input  logic [15:0]                in_dr_dlid,
  input  logic [PATH_LEN*PORT_W-1:0] in_fwd_path,
  input  logic [PATH_LEN*PORT_W-1:0] in_ret_path,
  input  logic                       cfg_is_switch,
  input  logic [15:0]                cfg_own_lid,
  input  logic [PORT_W-1:0]          cfg_in_port,
  output logic                       out_valid,
  input  logic                       out_ready,
  output logic [2:0]                 out_action,
  output logic [PORT_W-1:0]          out_port,
  output logic [PTR_W-1:0]           out_hop_ptr,
  output logic [15:0]                out_slid,
  output logic [15:0]                out_dlid,
  output logic [PATH_LEN*PORT_W-1:0] out_ret_path
);
  localparam int ARR_W = PATH_LEN * PORT_W;
  localparam int OUT_W = 3 + PORT_W + PTR_W + 2 * LID_W + ARR_W;

  hop_kind_e         kind;
  hop_act_e          act;
  logic [PORT_W-1:0] eg_port;
  logic [PTR_W-1:0]  ptr_n;
  logic [LID_W-1:0]  slid_n;
  logic [LID_W-1:0]  dlid_n;
  logic [ARR_W-1:0]  ret_n;
  logic [OUT_W-1:0]  res_d;
  logic [OUT_W-1:0]  res_q;

  dr_hop_classify #(.PATH_LEN(PATH_LEN), .PTR_W(PTR_W)) u_cls (
    .dir       (in_dir),
    .hop_cnt   (in_hop_cnt),
    .hop_ptr   (in_hop_ptr),
    .dlid      (in_dlid),
    .is_switch (cfg_is_switch),
    .kind      (kind)
  );

  dr_hop_rewrite #(.PATH_LEN(PATH_LEN), .PTR_W(PTR_W), .PORT_W(PORT_W)) u_rw (
    .kind      (kind),
    .hop_cnt   (in_hop_cnt),
    .hop_ptr   (in_hop_ptr),
    .slid      (in_slid),
    .dlid      (in_dlid),
    .dr_dlid   (in_dr_dlid),
    .fwd_path  (in_fwd_path),
    .ret_path  (in_ret_path),
    .is_switch (cfg_is_switch),
    .own_lid   (cfg_own_lid),
    .in_port   (cfg_in_port),
    .act       (act),
    .eg_port   (eg_port),
    .ptr_n     (ptr_n),
    .slid_n    (slid_n),
    .dlid_n    (dlid_n),
    .ret_n     (ret_n)
  );

  assign res_d = {act, eg_port, ptr_n, slid_n, dlid_n, ret_n};

  dr_hop_oreg #(.W(OUT_W)) u_oreg (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .d         (res_d),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .q         (res_q)
  );

  assign {out_action, out_port, out_hop_ptr, out_slid, out_dlid, out_ret_path} = res_q;
endmodule

// File: rtl/dr_fwd_hop_chk.sv
`timescale 1ns/1ps
module dr_fwd_hop_chk #(
  parameter int PATH_LEN = 64,
  parameter int PTR_W    = 8,
  parameter int PORT_W   = 8
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       in_valid,
  input logic                       in_ready,
  input logic                       in_dir,
  input logic [PTR_W-1:0]           in_hop_cnt,
  input logic [PTR_W-1:0]           in_hop_ptr,
  input logic [15:0]                in_slid,
  input logic [15:0]                in_dlid,
  input logic [15:0]                in_dr_dlid,
  input logic [PATH_LEN*PORT_W-1:0] in_fwd_path,
  input logic [PATH_LEN*PORT_W-1:0] in_ret_path,
  input logic                       cfg_is_switch,
  input logic [15:0]                cfg_own_lid,
  input logic [PORT_W-1:0]          cfg_in_port,
  input logic                       out_valid,
  input logic                       out_ready,
  input logic [2:0]                 out_action,
  input logic [PORT_W-1:0]          out_port,
  input logic [PTR_W-1:0]           out_hop_ptr,
  input logic [15:0]                out_slid,
  input logic [15:0]                out_dlid,
  input logic [PATH_LEN*PORT_W-1:0] out_ret_path
);
  localparam logic [PTR_W-1:0] MAXC = PTR_W'(PATH_LEN - 1);

  logic acc;
  assign acc = in_valid && in_ready;

  // R1
  ready_when_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> in_ready);

  // R1
  accept_gives_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> out_valid);

  // R2
  hold_while_stalled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_action) && $stable(out_port)
      && $stable(out_hop_ptr) && $stable(out_slid) && $stable(out_dlid)
      && $stable(out_ret_path)));

  // R3
  return_dir_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && in_dir) |=> (out_action == 3'd3 && out_slid == $past(in_slid)
      && out_dlid == $past(in_dlid) && out_hop_ptr == $past(in_hop_ptr)));

  // R4
  ptr_over_cnt_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !in_dir && cfg_is_switch && in_hop_ptr > in_hop_cnt) |=> out_action == 3'd4);

  // R7
  switch_mid_rewrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !in_dir && cfg_is_switch && in_hop_ptr < in_hop_cnt && in_hop_cnt <= MAXC)
      |=> (out_action == 3'd0 && out_slid == 16'hFFFF && out_dlid == 16'hFFFF
           && out_hop_ptr == $past(in_hop_ptr) + PTR_W'(1)));

  // R10
  switch_last_lookup_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !in_dir && cfg_is_switch && in_hop_ptr == in_hop_cnt && in_hop_cnt <= MAXC
      && in_dr_dlid != 16'hFFFF)
      |=> (out_action == 3'd1 && out_dlid == $past(in_dr_dlid)
           && out_slid == $past(cfg_own_lid) && out_port == '0));
endmodule

bind dr_fwd_hop dr_fwd_hop_chk #(.PATH_LEN(PATH_LEN), .PTR_W(PTR_W), .PORT_W(PORT_W)) u_chk (.*);

// File: tb/sim_dr_fwd_hop.sv
`timescale 1ns/1ps
module sim_dr_fwd_hop;
  localparam int PL = 64;
  localparam int AW = PL * 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic          in_valid = 1'b0, in_ready, in_dir = 1'b0;
  logic [7:0]    in_hop_cnt = '0, in_hop_ptr = '0;
  logic [15:0]   in_slid = '0, in_dlid = '0, in_dr_dlid = '0;
  logic [AW-1:0] in_fwd_path = '0, in_ret_path = '0;
  logic          cfg_is_switch = 1'b0;
  logic [15:0]   cfg_own_lid = '0;
  logic [7:0]    cfg_in_port = '0;
  logic          out_valid, out_ready = 1'b1;
  logic [2:0]    out_action;
  logic [7:0]    out_port, out_hop_ptr;
  logic [15:0]   out_slid, out_dlid;
  logic [AW-1:0] out_ret_path;

  dr_fwd_hop u0 (.*);

  typedef struct {
    logic [2:0]    act;
    logic [7:0]    port;
    logic [7:0]    ptr;
    logic [15:0]   slid;
    logic [15:0]   dlid;
    logic [AW-1:0] ret;
    string         tag;
  } exp_t;

  exp_t sb[$];
  int n_chk = 0, n_fail = 0;
  bit stall_mode = 1'b0;
  bit done = 1'b0;
  int cyc = 0;
  logic [AW-1:0] fwd_v, ret_v;

  task automatic do_chk(input bit ok, input string tag, input string what,
                        input logic [AW-1:0] got, input logic [AW-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s got=%0h exp=%0h", tag, what, got, exp);
    end
  endtask

  // Expected result built from the written requirements
  function automatic exp_t model(input bit dir, input logic [7:0] cnt, input logic [7:0] ptr,
      input logic [15:0] slid, input logic [15:0] dlid, input logic [15:0] drd,
      input bit sw, input logic [15:0] own, input logic [7:0] inp, input string tag);
    exp_t e;
    e.act = 3'd3; e.port = '0; e.ptr = ptr; e.slid = slid; e.dlid = dlid;
    e.ret = ret_v; e.tag = tag;
    if (dir || (!sw && dlid != 16'hFFFF)) e.act = 3'd3;
    else if (cnt > 8'd63 || ptr > cnt) e.act = 3'd4;
    else if (ptr < cnt) begin
      if (ptr != 0 && sw) e.ret[int'(ptr)*8 +: 8] = inp;
      e.ptr = ptr + 8'd1;
      e.act = 3'd0;
      e.port = fwd_v[int'(ptr + 8'd1)*8 +: 8];
      e.slid = sw ? 16'hFFFF : own;
      e.dlid = 16'hFFFF;
    end else begin
      if (ptr != 0) e.ret[int'(ptr)*8 +: 8] = inp;
      e.ptr = cnt + 8'd1;
      if (drd == 16'hFFFF) begin
        e.act = 3'd2; e.slid = 16'hFFFF; e.dlid = 16'hFFFF;
      end else begin
        e.act = sw ? 3'd1 : 3'd2; e.slid = own; e.dlid = drd;
      end
    end
    return e;
  endfunction

  task automatic send(input bit dir, input logic [7:0] cnt, input logic [7:0] ptr,
      input logic [15:0] slid, input logic [15:0] dlid, input logic [15:0] drd,
      input bit sw, input logic [15:0] own, input logic [7:0] inp, input string tag);
    @(negedge clk);
    in_dir = dir; in_hop_cnt = cnt; in_hop_ptr = ptr; in_slid = slid; in_dlid = dlid;
    in_dr_dlid = drd; cfg_is_switch = sw; cfg_own_lid = own; cfg_in_port = inp;
    in_fwd_path = fwd_v; in_ret_path = ret_v; in_valid = 1'b1;
    while (!in_ready) @(negedge clk);
    sb.push_back(model(dir, cnt, ptr, slid, dlid, drd, sw, own, inp, tag));
    @(negedge clk);
    in_valid = 1'b0;
    // R1: result present one cycle after acceptance
    do_chk(out_valid == 1'b1, "R1", "out_valid after accept", AW'(out_valid), AW'(1));
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    #1 out_ready <= stall_mode ? ((cyc % 3) != 0) : 1'b1;
  end

  // Monitor: scoreboard pop and stall-hold comparison
  logic          held = 1'b0;
  logic [2:0]    h_act;
  logic [7:0]    h_port, h_ptr;
  logic [15:0]   h_slid, h_dlid;
  logic [AW-1:0] h_ret;
  always @(negedge clk) begin
    if (rst_n) begin
      if (held) begin
        // R2: stalled result must not move
        do_chk(out_valid && out_action == h_act && out_port == h_port && out_hop_ptr == h_ptr
               && out_slid == h_slid && out_dlid == h_dlid && out_ret_path == h_ret,
               "R2", "held output", AW'({out_action, out_port, out_hop_ptr, out_slid, out_dlid}),
               AW'({h_act, h_port, h_ptr, h_slid, h_dlid}));
      end
      held = out_valid && !out_ready;
      h_act = out_action; h_port = out_port; h_ptr = out_hop_ptr;
      h_slid = out_slid; h_dlid = out_dlid; h_ret = out_ret_path;
      if (out_valid && out_ready) begin
        if (sb.size() == 0) begin
          do_chk(1'b0, "R1", "unexpected result", AW'(out_action), AW'(0));
        end else begin
          exp_t e;
          e = sb.pop_front();
          do_chk(out_action == e.act, e.tag, "action", AW'(out_action), AW'(e.act));
          do_chk(out_port == e.port, e.tag, "port", AW'(out_port), AW'(e.port));
          do_chk(out_hop_ptr == e.ptr, e.tag, "hop_ptr", AW'(out_hop_ptr), AW'(e.ptr));
          do_chk(out_slid == e.slid, e.tag, "slid", AW'(out_slid), AW'(e.slid));
          do_chk(out_dlid == e.dlid, e.tag, "dlid", AW'(out_dlid), AW'(e.dlid));
          do_chk(out_ret_path == e.ret, e.tag, "ret_path", out_ret_path, e.ret);
        end
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(5.0 * 100000);
    n_chk++; n_fail++;
    $display("FAIL R1 watchdog got=hang exp=done");
    finish_run();
  end

  task automatic run_set(input string sfx);
    // R3: endpoint, addressed destination -> untouched
    send(0, 8'd3, 8'd0, 16'h0011, 16'h0012, 16'h0040, 0, 16'h0011, 8'd1, {"R3", sfx});
    // R5 R7 R8: endpoint at path start
    send(0, 8'd3, 8'd0, 16'h0011, 16'hFFFF, 16'h0040, 0, 16'h0021, 8'd1, {"R5 R7 R8", sfx});
    // R6 R7 R8: switch mid-path records arrival port
    send(0, 8'd3, 8'd1, 16'h0011, 16'hFFFF, 16'h0040, 1, 16'h0030, 8'd4, {"R6 R7 R8", sfx});
    // R5: switch at pointer 0
    send(0, 8'd2, 8'd0, 16'h0011, 16'h0030, 16'h0040, 1, 16'h0030, 8'd2, {"R5", sfx});
    // R6: endpoint mid-path writes nothing
    send(0, 8'd3, 8'd1, 16'h0011, 16'hFFFF, 16'h0040, 0, 16'h0022, 8'd5, {"R6", sfx});
    // R9 R10: switch final hop, addressed destination
    send(0, 8'd3, 8'd3, 16'hFFFF, 16'hFFFF, 16'h0040, 1, 16'h0030, 8'd3, {"R9 R10", sfx});
    // R9 R11: endpoint final hop, permissive destination
    send(0, 8'd2, 8'd2, 16'hFFFF, 16'hFFFF, 16'hFFFF, 0, 16'h0023, 8'd1, {"R9 R11", sfx});
    // R11: endpoint final hop, addressed destination
    send(0, 8'd2, 8'd2, 16'hFFFF, 16'hFFFF, 16'h0055, 0, 16'h0024, 8'd1, {"R11", sfx});
    // R4: pointer past count, and count out of range
    send(0, 8'd2, 8'd3, 16'h0011, 16'hFFFF, 16'h0040, 1, 16'h0030, 8'd1, {"R4", sfx});
    send(0, 8'd64, 8'd1, 16'h0011, 16'hFFFF, 16'h0040, 1, 16'h0030, 8'd1, {"R4", sfx});
    // R3: return direction on a switch
    send(1, 8'd3, 8'd2, 16'h0011, 16'hFFFF, 16'h0040, 1, 16'h0030, 8'd6, {"R3", sfx});
  endtask

  initial begin
    for (int i = 0; i < PL; i++) begin
      fwd_v[i*8 +: 8] = 8'((i * 5 + 1) & 8'hFF);
      ret_v[i*8 +: 8] = 8'(i ^ 8'hA5);
    end
    fwd_v[7:0] = 8'hEE;
    repeat (3) @(negedge clk);
    // R1: reset state
    do_chk(out_valid == 1'b0, "R1", "out_valid in reset", AW'(out_valid), AW'(0));
    rst_n = 1'b1;
    @(negedge clk);
    do_chk(in_ready == 1'b1, "R1", "in_ready after reset", AW'(in_ready), AW'(1));
    run_set("");
    // R8: top-of-range forward entry
    send(0, 8'd63, 8'd62, 16'h0011, 16'hFFFF, 16'h0040, 1, 16'h0030, 8'd7, "R8 R6");
    // R9: last entry of the return list
    send(0, 8'd63, 8'd63, 16'h0011, 16'hFFFF, 16'hFFFF, 1, 16'h0030, 8'd9, "R9 R11");
    // R9: zero-length route, pointer 0 writes nothing
    send(0, 8'd0, 8'd0, 16'h0011, 16'hFFFF, 16'hFFFF, 1, 16'h0030, 8'd9, "R9");
    stall_mode = 1'b1;
    run_set(" stall");
    repeat (20) @(negedge clk);
    while (sb.size() != 0) @(negedge clk);
    stall_mode = 1'b0;
    repeat (4) @(negedge clk);
    finish_run();
  end
endmodule